// File: doc/BRIEF.md
# Dual-Drive PIO Cycle Timing Generator

This block times a single programmed-I/O transfer on a storage channel that two drives share. When a request arrives while the block is idle, it captures the drive select, the transfer direction and the already-decoded timing settings. It then runs three phases in a fixed order:

- an address-setup phase,
- an active strobe phase, on the read strobe or the write strobe,
- a recovery phase.

A one-cycle done pulse ends the transfer.

Each drive is mapped to one of two timing banks. Each bank holds a read-timing byte and a write-timing byte. The upper nibble of the byte sets the strobe width and the lower nibble sets the recovery time. Address setup comes from one field that both drives share. The block also holds the read-prefetch permission and the ready-sample delay for the length of the transfer, so the surrounding channel logic can use them.

Top module: `pio_cycle_gen`

## Requirements
- R1: While reset is high, and after it, until a request is accepted: busy, addr_setup, rd_strobe, wr_strobe, recov, done and pf_en are 0, and drdy_len is 0.
- R2: A request is accepted only at a clock edge where the block is idle. addr_setup and busy go high in the cycle after that edge.
- R3: addr_setup stays high for setup_fld + 1 cycles. The field is shared, so the count is the same for both drives and both directions.
- R4: The strobe stays high for (selected timing byte bits [7:4]) + 1 cycles.
- R5: recov stays high for (selected timing byte bits [3:0]) + 2 cycles. It starts right after the strobe.
- R6: A read uses the bank's read-timing byte and drives only rd_strobe. A write uses the bank's write-timing byte and drives only wr_strobe. The two strobes are never high together, and neither is high outside the strobe phase.
- R7: The bank is bank_map[drive_sel]. Value 0 selects the rd_tim0/wr_tim0 pair and value 1 selects the rd_tim1/wr_tim1 pair.
- R8: done is high for exactly one cycle, right after recovery ends. busy stays high until that cycle and falls in the cycle after it.
- R9: A request raised while busy is high is ignored. It produces no extra transfer.
- R10: The settings are sampled at the accepting edge. Changes to timing bytes, bank_map, setup_fld, drdy_fld or prefetch_on during a transfer have no effect on that transfer.
- R11: pf_en equals prefetch_on for a read and is 0 for a write. drdy_len equals drdy_fld + 2. Both are held from the cycle after acceptance until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, sampled when idle |
| is_write | input | 1 | 1 = write transfer, 0 = read |
| drive_sel | input | 1 | Target drive (0 or 1) |
| bank_map | input | 2 | Bank index for each drive, bit d for drive d |
| rd_tim0 | input | 8 | Bank 0 read timing: [7:4] pulse−1, [3:0] recovery−2 |
| wr_tim0 | input | 8 | Bank 0 write timing, same layout |
| rd_tim1 | input | 8 | Bank 1 read timing, same layout |
| wr_tim1 | input | 8 | Bank 1 write timing, same layout |
| setup_fld | input | 2 | Shared address setup, minus 1 |
| drdy_fld | input | 2 | Ready-sample delay, minus 2 |
| prefetch_on | input | 1 | Read prefetch permitted |
| busy | output | 1 | Transfer in progress |
| addr_setup | output | 1 | Address-setup phase |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| recov | output | 1 | Recovery phase |
| done | output | 1 | One-cycle end-of-transfer pulse |
| pf_en | output | 1 | Prefetch enable for the current transfer |
| drdy_len | output | 3 | Ready-sample delay in clocks |

## Verification
Transfers are run with the smallest fields (strobe 1, recovery 2, setup 1) and the largest fields (16, 17, 4). This shows whether the offsets and counter limits are applied correctly. Reads and writes are sent to both drives under direct, swapped and shared bank maps, with different bytes in every bank slot. A wrong bank or direction choice therefore gives a wrong cycle count. Further transfers change every setting mid-transfer, or raise a request while busy, to show that sampling happens only at acceptance. The prefetch and ready-delay outputs are checked for reads and writes with both field values.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOVER,
    ST_DONE
  } pio_state_t;

  localparam int PULSE_OFS = 1;
  localparam int REC_OFS   = 2;
  localparam int SETUP_OFS = 1;
  localparam int DRDY_OFS  = 2;
endpackage

// File: rtl/pio_tim_select.sv
module pio_tim_select #(
  parameter int PULSE_W = 4,
  parameter int REC_W   = 4,
  parameter int SET_W   = 2,
  parameter int CNT_W   = 5,
  localparam int BYTE_W = PULSE_W + REC_W
) (
  input  logic              is_write,
  input  logic              drive_sel,
  input  logic [1:0]        bank_map,
  input  logic [BYTE_W-1:0] rd_tim0,
  input  logic [BYTE_W-1:0] wr_tim0,
  input  logic [BYTE_W-1:0] rd_tim1,
  input  logic [BYTE_W-1:0] wr_tim1,
  input  logic [SET_W-1:0]  setup_fld,
  output logic [CNT_W-1:0]  setup_len,
  output logic [CNT_W-1:0]  pulse_len,
  output logic [CNT_W-1:0]  rec_len
);
  import pio_tim_pkg::*;

  logic [3:0][BYTE_W-1:0] slot;
  logic [3:0][CNT_W-1:0]  slot_pulse;
  logic [3:0][CNT_W-1:0]  slot_rec;
  logic [1:0]             idx;

  assign slot = {wr_tim1, rd_tim1, wr_tim0, rd_tim0};

  for (genvar g = 0; g < 4; g++) begin : g_slot
    assign slot_pulse[g] = CNT_W'(slot[g][BYTE_W-1:REC_W]) + CNT_W'(PULSE_OFS);
    assign slot_rec[g]   = CNT_W'(slot[g][REC_W-1:0]) + CNT_W'(REC_OFS);
  end

  assign idx       = {bank_map[drive_sel], is_write};
  assign pulse_len = slot_pulse[idx];
  assign rec_len   = slot_rec[idx];
  assign setup_len = CNT_W'(setup_fld) + CNT_W'(SETUP_OFS);
endmodule

// File: rtl/pio_phase_ctr.sv
module pio_phase_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R3/R4/R5: a phase never counts below zero
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);
endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen #(
  parameter int PULSE_W = 4,
  parameter int REC_W   = 4,
  parameter int SET_W   = 2,
  parameter int DRDY_W  = 2,
  localparam int BYTE_W = PULSE_W + REC_W,
  localparam int CNT_W  = $clog2((2 ** REC_W) + 2),
  localparam int DLEN_W = DRDY_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_write,
  input  logic              drive_sel,
  input  logic [1:0]        bank_map,
  input  logic [BYTE_W-1:0] rd_tim0,
  input  logic [BYTE_W-1:0] wr_tim0,
  input  logic [BYTE_W-1:0] rd_tim1,
  input  logic [BYTE_W-1:0] wr_tim1,
  input  logic [SET_W-1:0]  setup_fld,
  input  logic [DRDY_W-1:0] drdy_fld,
  input  logic              prefetch_on,
  output logic              busy,
  output logic              addr_setup,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              recov,
  output logic              done,
  output logic              pf_en,
  output logic [DLEN_W-1:0] drdy_len
);
  import pio_tim_pkg::*;

  pio_state_t       st, nxt;
  logic [CNT_W-1:0] sel_setup, sel_pulse, sel_rec;
  logic [CNT_W-1:0] lat_pulse, lat_rec, ld_val;
  logic             lat_wr, ld, dec, zero, accept;

  pio_tim_select #(
    .PULSE_W(PULSE_W), .REC_W(REC_W), .SET_W(SET_W), .CNT_W(CNT_W)
  ) u_sel (
    .is_write (is_write),
    .drive_sel(drive_sel),
    .bank_map (bank_map),
    .rd_tim0  (rd_tim0),
    .wr_tim0  (wr_tim0),
    .rd_tim1  (rd_tim1),
    .wr_tim1  (wr_tim1),
    .setup_fld(setup_fld),
    .setup_len(sel_setup),
    .pulse_len(sel_pulse),
    .rec_len  (sel_rec)
  );

  pio_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (ld),
    .load_val(ld_val),
    .dec     (dec),
    .zero    (zero)
  );

  assign accept = (st == ST_IDLE) && req;

  always_comb begin
    nxt    = st;
    ld     = 1'b0;
    dec    = 1'b0;
    ld_val = '0;
    unique case (st)
      ST_IDLE: if (req) begin
        nxt = ST_SETUP; ld = 1'b1; ld_val = sel_setup - 1'b1;
      end
      ST_SETUP: if (zero) begin
        nxt = ST_ACTIVE; ld = 1'b1; ld_val = lat_pulse - 1'b1;
      end else dec = 1'b1;
      ST_ACTIVE: if (zero) begin
        nxt = ST_RECOVER; ld = 1'b1; ld_val = lat_rec - 1'b1;
      end else dec = 1'b1;
      ST_RECOVER: if (zero) nxt = ST_DONE;
                  else      dec = 1'b1;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      lat_pulse  <= '0;
      lat_rec    <= '0;
      lat_wr     <= 1'b0;
      busy       <= 1'b0;
      addr_setup <= 1'b0;
      rd_strobe  <= 1'b0;
      wr_strobe  <= 1'b0;
      recov      <= 1'b0;
      done       <= 1'b0;
      pf_en      <= 1'b0;
      drdy_len   <= '0;
    end else begin
      st <= nxt;
      if (accept) begin
        lat_pulse <= sel_pulse;
        lat_rec   <= sel_rec;
        lat_wr    <= is_write;
        pf_en     <= prefetch_on && !is_write;
        drdy_len  <= DLEN_W'(drdy_fld) + DLEN_W'(DRDY_OFS);
      end
      busy       <= (nxt != ST_IDLE);
      addr_setup <= (nxt == ST_SETUP);
      rd_strobe  <= (nxt == ST_ACTIVE) && !lat_wr;
      wr_strobe  <= (nxt == ST_ACTIVE) && lat_wr;
      recov      <= (nxt == ST_RECOVER);
      done       <= (nxt == ST_DONE);
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));
  p_strobe_in_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || wr_strobe) |-> (busy && !addr_setup && !recov && !done));
  p_recov_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(recov) |-> $past(rd_strobe || wr_strobe));
  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_setup) |-> $past(!busy));
  p_hold_settings_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !$rose(busy)) |-> ($stable(pf_en) && $stable(drdy_len)));
endmodule

// File: tb/sim_pio_cycle_gen.sv
module sim_pio_cycle_gen;
  typedef struct {
    int s; int p; int r; bit wr; bit pf; int dl;
  } exp_t;

  logic       clk = 1'b0, rst = 1'b1, req = 1'b0, is_write = 1'b0, drive_sel = 1'b0;
  logic [1:0] bank_map = 2'b10, setup_fld = 2'd0, drdy_fld = 2'd0;
  logic [7:0] rd_tim0 = 8'h00, wr_tim0 = 8'h00, rd_tim1 = 8'h00, wr_tim1 = 8'h00;
  logic       prefetch_on = 1'b0;
  logic       busy, addr_setup, rd_strobe, wr_strobe, recov, done, pf_en;
  logic [2:0] drdy_len;

  int   n_chk = 0, n_fail = 0, n_done = 0, n_issued = 0, cyc = 0;
  int   c_s = 0, c_rd = 0, c_wr = 0, c_r = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  pio_cycle_gen u0 (
    .clk(clk), .rst(rst), .req(req), .is_write(is_write), .drive_sel(drive_sel),
    .bank_map(bank_map), .rd_tim0(rd_tim0), .wr_tim0(wr_tim0), .rd_tim1(rd_tim1),
    .wr_tim1(wr_tim1), .setup_fld(setup_fld), .drdy_fld(drdy_fld),
    .prefetch_on(prefetch_on), .busy(busy), .addr_setup(addr_setup),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .recov(recov), .done(done),
    .pf_en(pf_en), .drdy_len(drdy_len)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_up();
    end
  end

  // monitor: count phase lengths, compare on done
  always @(negedge clk) begin
    if (!rst) begin
      if (addr_setup) c_s++;
      if (rd_strobe)  c_rd++;
      if (wr_strobe)  c_wr++;
      if (recov)      c_r++;
      if (done) begin
        n_done++;
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected transfer", n_done, n_issued);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(c_s == e.s, "R3 setup cycles", c_s, e.s);
          chk((e.wr ? c_wr : c_rd) == e.p, "R4 strobe cycles", e.wr ? c_wr : c_rd, e.p);
          chk((e.wr ? c_rd : c_wr) == 0, "R6 wrong strobe cycles", e.wr ? c_rd : c_wr, 0);
          chk(c_r == e.r, "R5 recovery cycles", c_r, e.r);
          chk(pf_en == e.pf, "R11 pf_en", int'(pf_en), int'(e.pf));
          chk(int'(drdy_len) == e.dl, "R11 drdy_len", int'(drdy_len), e.dl);
        end
        c_s = 0; c_rd = 0; c_wr = 0; c_r = 0;
      end
    end
  end

  function automatic exp_t model(input bit drv, input bit wr);
    exp_t e;
    logic [7:0] b;
    logic bank;
    bank = bank_map[drv];
    if (bank) b = wr ? wr_tim1 : rd_tim1;
    else      b = wr ? wr_tim0 : rd_tim0;
    e.s  = int'(setup_fld) + 1;
    e.p  = int'(b[7:4]) + 1;
    e.r  = int'(b[3:0]) + 2;
    e.wr = wr;
    e.pf = wr ? 1'b0 : prefetch_on;
    e.dl = int'(drdy_fld) + 2;
    return e;
  endfunction

  // mode 0 plain, 1 scramble settings mid-transfer (R10), 2 extra req while busy (R9)
  task automatic xfer(input bit drv, input bit wr, input int mode);
    logic [7:0] s0, s1, s2, s3;
    logic [1:0] sm, ss, sd;
    logic sp;
    int gap;
    @(negedge clk);
    drive_sel = drv; is_write = wr; req = 1'b1;
    q.push_back(model(drv, wr));
    n_issued++;
    @(negedge clk);
    req = 1'b0;
    chk(busy && addr_setup, "R2 accept starts setup", int'(busy), 1);
    if (mode == 1) begin
      s0 = rd_tim0; s1 = wr_tim0; s2 = rd_tim1; s3 = wr_tim1;
      sm = bank_map; ss = setup_fld; sd = drdy_fld; sp = prefetch_on;
      rd_tim0 = ~s0; wr_tim0 = ~s1; rd_tim1 = ~s2; wr_tim1 = ~s3;
      bank_map = ~sm; setup_fld = ~ss; drdy_fld = ~sd; prefetch_on = ~sp;
      is_write = ~wr; drive_sel = ~drv;
      while (busy) @(negedge clk);
      rd_tim0 = s0; wr_tim0 = s1; rd_tim1 = s2; wr_tim1 = s3;
      bank_map = sm; setup_fld = ss; drdy_fld = sd; prefetch_on = sp;
    end else if (mode == 2) begin
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      while (busy) @(negedge clk);
    end else begin
      while (busy) @(negedge clk);
    end
    gap = 0;
    repeat (3) begin
      @(negedge clk);
      if (busy) gap++;
    end
    chk(gap == 0, "R8/R9 idle after done", gap, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, addr_setup, rd_strobe, wr_strobe, recov, done, pf_en} == 7'b0,
        "R1 outputs in reset", int'(busy), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk({busy, addr_setup, rd_strobe, wr_strobe, recov, done, pf_en} == 7'b0 && drdy_len == 3'd0,
        "R1 idle after reset", int'(drdy_len), 0);

    // minimal fields (R4 R5 R3)
    rd_tim0 = 8'h00; wr_tim0 = 8'hFF; rd_tim1 = 8'h35; wr_tim1 = 8'h52;
    xfer(1'b0, 1'b0, 0);
    // maximal fields, write bank 0 (R6)
    setup_fld = 2'd3;
    xfer(1'b0, 1'b1, 0);
    // drive 1 bank 1 read / write (R7)
    setup_fld = 2'd1;
    xfer(1'b1, 1'b0, 0);
    prefetch_on = 1'b1; drdy_fld = 2'd3;
    xfer(1'b1, 1'b1, 0);
    xfer(1'b1, 1'b0, 0);
    // swapped map (R7)
    bank_map = 2'b01; drdy_fld = 2'd1;
    xfer(1'b0, 1'b0, 0);
    xfer(1'b1, 1'b1, 0);
    // shared bank 0 (R7), same setup for both drives (R3)
    bank_map = 2'b00; setup_fld = 2'd2; prefetch_on = 1'b0;
    xfer(1'b1, 1'b0, 0);
    xfer(1'b0, 1'b0, 0);
    // mid-transfer changes ignored (R10)
    bank_map = 2'b10; rd_tim0 = 8'h21; wr_tim1 = 8'h13; prefetch_on = 1'b1;
    xfer(1'b0, 1'b0, 1);
    xfer(1'b1, 1'b1, 1);
    // request while busy ignored (R9)
    xfer(1'b1, 1'b0, 2);
    xfer(1'b0, 1'b1, 2);

    repeat (5) @(negedge clk);
    chk(n_done == n_issued, "R9 transfer count", n_done, n_issued);
    chk(q.size() == 0, "R8 all transfers completed", q.size(), 0);
    finish_up();
  end
endmodule